// File: doc/BRIEF.md
# Clock-Stop Suspend Sequencer

This block walks a system into and back out of a deep suspend state in which the main clocks are gated off. A power-management agent asks for entry by raising a go input. If clock-stop is enabled in the configuration, the block raises its suspend request to the processor and waits for the acknowledge. Once the acknowledge is seen, the block raises a clock-stop indicator that the clock generators use as their enable, and the main clocks stop.

The whole sequencer runs from a free-running 32 kHz slow clock, so it keeps counting and keeps accepting wake events while the main clocks are off. Either an SMI event or an unmasked interrupt drops the clock-stop indicator, and the clocks restart. The suspend request is then held through a programmable PLL re-lock window of 0 to 15 ms, and the SMI output is held for that whole window. The processor therefore enters its management mode once it runs again. A wake that arrives while the handshake is still in progress cancels the entry.

Top module: `clkstop_seq`

## Requirements
- R1: In the idle state, `sleep_go_i` sampled high with `cfg_stop_en` = 1 and no wake input raises `susp_req_o` after that same edge. If `cfg_stop_en` = 0, or a wake input is high at that edge, the go input is ignored and `susp_req_o` stays low.
- R2: While the request is up and the block waits for the acknowledge, `clk_stop_o` rises after the first edge at which `susp_ack_i` is high and no wake input is high. It never rises before that.
- R3: During and right after reset, `susp_req_o`, `clk_stop_o` and `smi_o` are all 0.
- R4: While `clk_stop_o` is high, `smi_evt_i` or `irq_wake_i` high at an edge drops `clk_stop_o` after that edge and raises `smi_o` at the same time. `susp_req_o` stays high.
- R5: `cfg_resync_ms` (4 bits, 1 ms per unit, 1 ms = 33 slow-clock periods) is sampled at the wake edge. `susp_req_o` then stays high for exactly `cfg_resync_ms`*33+1 slow-clock periods after that edge. A later change of `cfg_resync_ms` has no effect on the window already running.
- R6: `smi_o` stays high for the whole re-lock window and falls at the same edge as `susp_req_o`.
- R7: A wake input high at an edge while the block waits for the acknowledge cancels entry. `susp_req_o` falls after that edge and `clk_stop_o` never rises, even if `susp_ack_i` is high at the same edge.
- R8: After the request falls, `sleep_go_i` is ignored until `susp_ack_i` is sampled low. The block is idle after that edge and accepts a new entry at the next edge.
- R9: With `cfg_resync_ms` = 0, `susp_req_o` and `smi_o` fall after the first slow-clock edge that follows the wake edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Free-running 32 kHz clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_stop_en | input | 1 | Clock-stop feature enable |
| cfg_resync_ms | input | 4 | PLL re-lock delay in milliseconds |
| sleep_go_i | input | 1 | Request to enter clock-stop suspend |
| susp_ack_i | input | 1 | Processor suspend acknowledge |
| smi_evt_i | input | 1 | SMI wake event |
| irq_wake_i | input | 1 | Unmasked interrupt wake event |
| susp_req_o | output | 1 | Suspend request to the processor |
| clk_stop_o | output | 1 | Clock-stop indicator, gates the main clocks |
| smi_o | output | 1 | SMI held during the re-lock window |

## Verification
Every output is a state decode, so each result shows up after the single slow-clock edge that samples the stimulus. Entry, the acknowledge, a wake and a cancel are each visible at the following falling edge. The end of the re-lock window comes `cfg_resync_ms`*33+1 edges after the wake edge. The bench drives inputs on falling edges and lets a behavioural model update on rising edges, then compares all three outputs with it at every falling edge. The window checks count the falling edges on which the request is still high, starting right after the wake edge, and compare that count with the R5 formula.

// File: rtl/clkstop_seq.sv
module clkstop_seq #(
  parameter int MS_W         = 4,
  parameter int TICKS_PER_MS = 33
) (
  input  logic            clk_slow,
  input  logic            rst_n,
  input  logic            cfg_stop_en,
  input  logic [MS_W-1:0] cfg_resync_ms,
  input  logic            sleep_go_i,
  input  logic            susp_ack_i,
  input  logic            smi_evt_i,
  input  logic            irq_wake_i,
  output logic            susp_req_o,
  output logic            clk_stop_o,
  output logic            smi_o
);

  localparam int MAX_TICKS = ((1 << MS_W) - 1) * TICKS_PER_MS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  typedef enum logic [2:0] {IDLE, WAIT_ACK, STOPPED, RESYNC, DONE} st_t;

  st_t              st;
  logic [CNT_W-1:0] hold_cnt;
  logic             wake;

  assign wake = smi_evt_i | irq_wake_i;

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      hold_cnt <= '0;
    end else begin
      case (st)
        IDLE:     if (sleep_go_i && cfg_stop_en && !wake) st <= WAIT_ACK;
        WAIT_ACK: if (wake) st <= DONE;
                  else if (susp_ack_i) st <= STOPPED;
        STOPPED:  if (wake) begin
                    st       <= RESYNC;
                    hold_cnt <= CNT_W'(cfg_resync_ms) * CNT_W'(TICKS_PER_MS);
                  end
        RESYNC:   if (hold_cnt == '0) st <= DONE;
                  else hold_cnt <= hold_cnt - 1'b1;
        DONE:     if (!susp_ack_i) st <= IDLE;
        default:  st <= IDLE;
      endcase
    end
  end

  assign susp_req_o = (st == WAIT_ACK) | (st == STOPPED) | (st == RESYNC);
  assign clk_stop_o = (st == STOPPED);
  assign smi_o      = (st == RESYNC);

  AST_ENTRY_NEEDS_EN: assert property (@(posedge clk_slow) disable iff (!rst_n)
    $rose(susp_req_o) |-> $past(cfg_stop_en) && $past(sleep_go_i)) else $error("entry"); // R1
  AST_STOP_AFTER_ACK: assert property (@(posedge clk_slow) disable iff (!rst_n)
    $rose(clk_stop_o) |-> $past(susp_ack_i) && $past(susp_req_o)) else $error("stop"); // R2
  AST_WAKE_EXITS: assert property (@(posedge clk_slow) disable iff (!rst_n)
    clk_stop_o && (smi_evt_i || irq_wake_i) |=> !clk_stop_o && smi_o && susp_req_o) else $error("wake"); // R4
  AST_SMI_DROP_WITH_REQ: assert property (@(posedge clk_slow) disable iff (!rst_n)
    $fell(smi_o) |-> $fell(susp_req_o)) else $error("smi"); // R6
  AST_CANCEL: assert property (@(posedge clk_slow) disable iff (!rst_n)
    susp_req_o && !clk_stop_o && !smi_o && (smi_evt_i || irq_wake_i) |=> !susp_req_o && !clk_stop_o) else $error("cancel"); // R7

endmodule

// File: tb/sim_clkstop_seq.sv
module sim_clkstop_seq;
  logic clk_slow = 1'b0;
  always #2 clk_slow = ~clk_slow;

  logic rst_n, cfg_stop_en, sleep_go_i, susp_ack_i, smi_evt_i, irq_wake_i;
  logic [3:0] cfg_resync_ms;
  logic susp_req_o, clk_stop_o, smi_o;

  clkstop_seq u0 (.clk_slow(clk_slow), .rst_n(rst_n), .cfg_stop_en(cfg_stop_en),
    .cfg_resync_ms(cfg_resync_ms), .sleep_go_i(sleep_go_i), .susp_ack_i(susp_ack_i),
    .smi_evt_i(smi_evt_i), .irq_wake_i(irq_wake_i), .susp_req_o(susp_req_o),
    .clk_stop_o(clk_stop_o), .smi_o(smi_o));

  int checks = 0, errors = 0;
  bit finished = 0;
  string tag = "R3";

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // behavioural model: phase 0 idle, 1 asking, 2 clocks off, 3 relock, 4 wait ack low
  int phase = 0, remain = 0;
  always @(posedge clk_slow) begin
    bit w;
    w = smi_evt_i || irq_wake_i;
    if (!rst_n) begin
      phase = 0; remain = 0;
    end else if (phase == 0) begin
      if (sleep_go_i && cfg_stop_en && !w) phase = 1;
    end else if (phase == 1) begin
      if (w) phase = 4; else if (susp_ack_i) phase = 2;
    end else if (phase == 2) begin
      if (w) begin phase = 3; remain = 33 * int'(cfg_resync_ms) + 1; end
    end else if (phase == 3) begin
      remain = remain - 1;
      if (remain == 0) phase = 4;
    end else if (!susp_ack_i) phase = 0;
  end

  always @(negedge clk_slow) begin
    if (rst_n && !finished) begin
      chk(susp_req_o == (phase >= 1 && phase <= 3), tag, "susp_req_o", susp_req_o, (phase >= 1 && phase <= 3));
      chk(clk_stop_o == (phase == 2), tag, "clk_stop_o", clk_stop_o, (phase == 2));
      chk(smi_o == (phase == 3), tag, "smi_o", smi_o, (phase == 3));
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk_slow);
  endtask

  task automatic enter_and_stop();
    sleep_go_i = 1; tick(); sleep_go_i = 0;
    susp_ack_i = 1; tick(2);
  endtask

  task automatic window(int ms, bit use_smi, string rq);
    int cnt;
    cfg_resync_ms = 4'(ms);
    if (use_smi) smi_evt_i = 1; else irq_wake_i = 1;
    tick();
    smi_evt_i = 0; irq_wake_i = 0;
    cfg_resync_ms = 4'(ms ^ 9);
    chk(clk_stop_o == 0 && smi_o == 1, "R4", "stop=0 smi=1 after wake", {clk_stop_o, smi_o}, 1);
    cnt = 0;
    while (susp_req_o && cnt < 1000) begin
      chk(smi_o == 1, "R6", "smi held in window", smi_o, 1);
      cnt++; tick();
    end
    chk(cnt == ms * 33 + 1, rq, "window length", cnt, ms * 33 + 1);
    chk(smi_o == 0, "R6", "smi falls with request", smi_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_slow);
    if (!finished) begin
      finished = 1; checks++; errors++;
      $display("FAIL watchdog all requirements actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_stop_en = 0; cfg_resync_ms = 0; sleep_go_i = 0;
    susp_ack_i = 0; smi_evt_i = 0; irq_wake_i = 0;
    tick(3);
    chk({susp_req_o, clk_stop_o, smi_o} == 3'b000, "R3", "outputs in reset", {susp_req_o, clk_stop_o, smi_o}, 0);
    rst_n = 1; tick();
    chk({susp_req_o, clk_stop_o, smi_o} == 3'b000, "R3", "outputs after reset", {susp_req_o, clk_stop_o, smi_o}, 0);

    tag = "R1";
    sleep_go_i = 1; tick(3); sleep_go_i = 0;
    chk(susp_req_o == 0, "R1", "disabled entry ignored", susp_req_o, 0);
    cfg_stop_en = 1;
    sleep_go_i = 1; irq_wake_i = 1; tick();
    sleep_go_i = 0; irq_wake_i = 0;
    chk(susp_req_o == 0, "R1", "go with wake ignored", susp_req_o, 0);
    sleep_go_i = 1; tick(); sleep_go_i = 0;
    chk(susp_req_o == 1, "R1", "request raised", susp_req_o, 1);

    tag = "R2";
    tick(3);
    chk(clk_stop_o == 0, "R2", "no stop before ack", clk_stop_o, 0);
    susp_ack_i = 1; tick();
    chk(clk_stop_o == 1, "R2", "stop after ack", clk_stop_o, 1);
    tick(5);
    chk(clk_stop_o == 1, "R2", "stop held", clk_stop_o, 1);

    tag = "R5";
    window(2, 0, "R5");

    tag = "R8";
    sleep_go_i = 1; tick(3); sleep_go_i = 0;
    chk(susp_req_o == 0, "R8", "go ignored while ack high", susp_req_o, 0);
    susp_ack_i = 0; tick();
    sleep_go_i = 1; tick(); sleep_go_i = 0;
    chk(susp_req_o == 1, "R8", "entry after ack low", susp_req_o, 1);

    tag = "R9";
    susp_ack_i = 1; tick(2);
    window(0, 1, "R9");
    susp_ack_i = 0; tick(2);

    tag = "R7";
    sleep_go_i = 1; tick(); sleep_go_i = 0;
    susp_ack_i = 1; irq_wake_i = 1; tick(); irq_wake_i = 0;
    chk(susp_req_o == 0 && clk_stop_o == 0, "R7", "cancel beats ack", {susp_req_o, clk_stop_o}, 0);
    tick(3);
    chk(clk_stop_o == 0, "R7", "no stop after cancel", clk_stop_o, 0);
    susp_ack_i = 0; tick(2);
    sleep_go_i = 1; tick(); sleep_go_i = 0;
    smi_evt_i = 1; tick(); smi_evt_i = 0;
    chk(susp_req_o == 0, "R7", "cancel by smi", susp_req_o, 0);
    tick(2);

    tag = "R5";
    enter_and_stop();
    window(15, 1, "R5");
    susp_ack_i = 0; tick(2);
    enter_and_stop();
    window(7, 0, "R5");
    susp_ack_i = 0; tick(3);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule